// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block supervises software through a wide down-counter that runs through two timeout stages in a row. Software sets two preload values and turns the timer on. The counter then loads the first preload and counts down. If software does not reload it before it runs out, the block raises a sticky interrupt. It then loads the second preload and counts again. If that count also runs out, an active-low timeout pin goes low and stays low until the block is reset. What the board does with that pin is outside this block.

The counter moves only on cycles where the external `tick_i` input is high, so the timeout resolution is set by whatever produces the tick. All control goes through a plain, single-cycle register write port. Every write is accepted in the cycle it is presented and there is no back-pressure. A lock bit freezes the configuration for the rest of the session. Reload strobes and interrupt clears are still accepted while the lock is set.

Top module: `twostage_watchdog`

## Requirements
- R1: After reset, `irq_o`=0, `tout_n_o`=1, `stage_o`=0 (idle), `running_o`=0, and both preloads are 0.
- R2: Register map on `addr_i`:
  - 0 is control: bit 0 = run, bit 1 = lock.
  - 1 is the first preload.
  - 2 is the second preload.
  - 3 is the command register: bit 0 = reload, bit 1 = interrupt clear.
  - Writing run=1 while idle makes `stage_o`=1 and `running_o`=1 after the write's clock edge, with the counter holding the first preload.
- R3: The counter decrements only on clock edges where `tick_i` is high. A stage whose loaded value is N ends on the Nth ticked edge after the load.
- R4: When the first stage ends, `irq_o` rises on that same edge, `stage_o` becomes 2, and the counter holds the second preload.
- R5: When the second stage ends, `tout_n_o` goes low on that edge and `stage_o` becomes 3 (expired). The counter stops and further ticks do nothing.
- R6: Once `tout_n_o` is low, it stays low until reset. Neither a reload nor a disable releases it.
- R7: A reload command while `stage_o` is 1, 2 or 3 returns the block to stage 1 with the first preload loaded. A reload command while idle is ignored.
- R8: `irq_o` is sticky and is cleared by writing 1 to command bit 1. If the first stage ends in the same cycle as a clear, the interrupt stays set.
- R9: Once the lock bit is written as 1, later writes to control and to both preloads are ignored until reset. Reload and interrupt-clear commands still take effect.
- R10: A preload of 0 behaves as 1: that stage ends on the next ticked edge.
- R11: Writing run=0 while unlocked returns the block to idle (`stage_o`=0, `running_o`=0). `irq_o` keeps its value, and ticks have no effect while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Count enable; one countdown step per high cycle |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | CNT_W (35) | Write data |
| irq_o | output | 1 | Sticky first-stage interrupt |
| tout_n_o | output | 1 | Active-low latched second-stage timeout |
| stage_o | output | 2 | 0 idle, 1 first stage, 2 second stage, 3 expired |
| running_o | output | 1 | High whenever the timer is not idle |

## Verification
A wrong count value or a dropped decrement shows up as the stage change or the interrupt moving by one or more ticked edges. The bench therefore samples `stage_o`, `irq_o` and `tout_n_o` after every single tick near each boundary, not only at the end of a run.

A broken reload or lock shows up within one clock edge of the offending write, as a wrong `stage_o` or `running_o`. A preload that was corrupted under lock only shows up when the stage it governs ends. For that reason the lock scenario counts both stages to completion.

A latch that releases is caught right after the reload and the disable that follow a timeout.

// File: rtl/twd_pkg.sv
package twd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_FIRST   = 2'd1,
    ST_SECOND  = 2'd2,
    ST_EXPIRED = 2'd3
  } stage_e;

  localparam int ADDR_W = 2;

  // register addresses
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_PRE1 = 2'd1;
  localparam logic [ADDR_W-1:0] A_PRE2 = 2'd2;
  localparam logic [ADDR_W-1:0] A_CMD  = 2'd3;

  // bit positions
  localparam int CTRL_RUN   = 0;
  localparam int CTRL_LOCK  = 1;
  localparam int CMD_KICK   = 0;
  localparam int CMD_IRQCLR = 1;
endpackage

// File: rtl/twd_regs.sv
module twd_regs
  import twd_pkg::*;
#(
  parameter int CNT_W = 35
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  pre1_o,
  output logic [CNT_W-1:0]  pre2_o,
  output logic              lock_o,
  output logic              start_o,
  output logic              stop_o,
  output logic              kick_o,
  output logic              irq_clr_o
);
  logic             run_q, lock_q;
  logic [CNT_W-1:0] pre1_q, pre2_q;
  logic             ctrl_wr, pre1_wr, pre2_wr, cmd_wr;

  always_comb begin
    ctrl_wr   = wr_i && (addr_i == A_CTRL) && !lock_q;
    pre1_wr   = wr_i && (addr_i == A_PRE1) && !lock_q;
    pre2_wr   = wr_i && (addr_i == A_PRE2) && !lock_q;
    cmd_wr    = wr_i && (addr_i == A_CMD);
    start_o   = ctrl_wr && wdata_i[CTRL_RUN] && !run_q;
    stop_o    = ctrl_wr && !wdata_i[CTRL_RUN] && run_q;
    kick_o    = cmd_wr && wdata_i[CMD_KICK];
    irq_clr_o = cmd_wr && wdata_i[CMD_IRQCLR];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      lock_q <= 1'b0;
      pre1_q <= '0;
      pre2_q <= '0;
    end else begin
      if (ctrl_wr) begin
        run_q  <= wdata_i[CTRL_RUN];
        lock_q <= wdata_i[CTRL_LOCK];
      end
      if (pre1_wr) pre1_q <= wdata_i;
      if (pre2_wr) pre2_q <= wdata_i;
    end
  end

  assign pre1_o = pre1_q;
  assign pre2_o = pre2_q;
  assign lock_o = lock_q;

  // R9: a set lock freezes itself, the run bit and both preloads
  assert_lock_freezes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> (lock_q && $stable(run_q) && $stable(pre1_q) && $stable(pre2_q)));
endmodule

// File: rtl/twd_count.sv
module twd_count
  import twd_pkg::*;
#(
  parameter int CNT_W = 35
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             kick_i,
  input  logic [CNT_W-1:0] pre1_i,
  input  logic [CNT_W-1:0] pre2_i,
  output stage_e           stage_o,
  output logic             exp1_o,
  output logic             exp2_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  stage_e           stage_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load1, load2;
  logic             counting, kick_eff, hit;

  always_comb begin
    // a zero preload counts as one tick
    load1    = (pre1_i == '0) ? ONE : pre1_i;
    load2    = (pre2_i == '0) ? ONE : pre2_i;
    counting = (stage_q == ST_FIRST) || (stage_q == ST_SECOND);
    kick_eff = kick_i && (stage_q != ST_IDLE) && !stop_i;
    hit      = tick_i && counting && (cnt_q == ONE) && !kick_i && !stop_i;
    exp1_o   = hit && (stage_q == ST_FIRST);
    exp2_o   = hit && (stage_q == ST_SECOND);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= ST_IDLE;
      cnt_q   <= '0;
    end else if (stop_i) begin
      stage_q <= ST_IDLE;
    end else if (start_i || kick_eff) begin
      stage_q <= ST_FIRST;
      cnt_q   <= load1;
    end else if (exp1_o) begin
      stage_q <= ST_SECOND;
      cnt_q   <= load2;
    end else if (exp2_o) begin
      stage_q <= ST_EXPIRED;
      cnt_q   <= '0;
    end else if (tick_i && counting) begin
      cnt_q <= cnt_q - ONE;
    end
  end

  assign stage_o = stage_q;

  // R10: an active stage never holds a zero count
  assert_count_nonzero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((stage_q == ST_FIRST) || (stage_q == ST_SECOND)) |-> (cnt_q != '0));

  // R4: the end of stage one enters stage two holding the second preload
  assert_second_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    exp1_o |=> ((stage_q == ST_SECOND) && (cnt_q == $past(load2))));

  // R7: a reload of a live timer restarts stage one
  assert_kick_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    kick_eff |=> ((stage_q == ST_FIRST) && (cnt_q == $past(load1))));

  // R5: once expired, only reload, disable or reset can move the state
  assert_expired_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((stage_q == ST_EXPIRED) && !kick_i && !stop_i) |=> (stage_q == ST_EXPIRED));
endmodule

// File: rtl/twd_flags.sv
module twd_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic exp1_i,
  input  logic exp2_i,
  input  logic irq_clr_i,
  output logic irq_o,
  output logic tout_o
);
  logic irq_q, tout_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= 1'b0;
      tout_q <= 1'b0;
    end else begin
      irq_q  <= exp1_i || (irq_q && !irq_clr_i);
      tout_q <= tout_q || exp2_i;
    end
  end

  assign irq_o  = irq_q;
  assign tout_o = tout_q;

  // R8: a first-stage expiry sets the interrupt even against a clear
  assert_irq_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    exp1_i |=> irq_q);

  // R8: a clear with no expiry drops the interrupt
  assert_irq_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr_i && !exp1_i) |=> !irq_q);
endmodule

// File: rtl/twostage_watchdog.sv
module twostage_watchdog
  import twd_pkg::*;
#(
  parameter int CNT_W = 35
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             wr_i,
  input  logic [1:0]       addr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic             irq_o,
  output logic             tout_n_o,
  output logic [1:0]       stage_o,
  output logic             running_o
);
  logic [CNT_W-1:0] pre1, pre2;
  logic             lock, start, stop, kick, irq_clr;
  logic             exp1, exp2, tout;
  stage_e           stage;

  twd_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_i(wr_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .pre1_o(pre1), .pre2_o(pre2), .lock_o(lock), .start_o(start),
    .stop_o(stop), .kick_o(kick), .irq_clr_o(irq_clr)
  );

  twd_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .start_i(start),
    .stop_i(stop), .kick_i(kick), .pre1_i(pre1), .pre2_i(pre2),
    .stage_o(stage), .exp1_o(exp1), .exp2_o(exp2)
  );

  twd_flags u_flags (
    .clk(clk), .rst_n(rst_n), .exp1_i(exp1), .exp2_i(exp2),
    .irq_clr_i(irq_clr), .irq_o(irq_o), .tout_o(tout)
  );

  assign tout_n_o  = !tout;
  assign stage_o   = stage;
  assign running_o = (stage != ST_IDLE);

  // R6: the timeout pin never releases before reset
  assert_tout_latched_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !tout_n_o |=> !tout_n_o);

  // R11: an unlocked disable returns to idle
  assert_disable_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (stage_o == 2'd0));

  // R9: control writes while locked leave the idle/running state alone
  assert_locked_ctrl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && wr_i && (addr_i == A_CTRL)) |-> (!start && !stop));
endmodule

// File: tb/test_twostage_watchdog.sv
module test_twostage_watchdog;
  localparam int CLK_PERIOD = 10;
  localparam int W = 35;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tick_i = 1'b0;
  logic         wr_i = 1'b0;
  logic [1:0]   addr_i = '0;
  logic [W-1:0] wdata_i = '0;
  logic         irq_o, tout_n_o, running_o;
  logic [1:0]   stage_o;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  twostage_watchdog #(.CNT_W(W)) i_twostage_watchdog (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .irq_o(irq_o), .tout_n_o(tout_n_o),
    .stage_o(stage_o), .running_o(running_o)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tick_i = 1'b0; wr_i = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk);
    wr_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_i = 1'b1;
      @(negedge clk);
      tick_i = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    do_reset();
    check("R1", "irq", irq_o, 0);
    check("R1", "tout_n", tout_n_o, 1);
    check("R1", "stage", stage_o, 0);
    check("R1", "running", running_o, 0);
    // preloads reset to 0: enabling now behaves like a one-tick stage
    wr(2'd0, 1);
    ticks(1);
    check("R1", "stage after one tick with reset preloads", stage_o, 2);
  endtask

  task automatic t_basic();
    do_reset();
    wr(2'd1, 5); wr(2'd2, 3); wr(2'd0, 1);
    check("R2", "stage after enable", stage_o, 1);
    check("R2", "running after enable", running_o, 1);
    repeat (6) @(negedge clk);
    check("R3", "no count without tick", stage_o, 1);
    ticks(4);
    check("R3", "stage after 4 of 5 ticks", stage_o, 1);
    check("R4", "irq before first expiry", irq_o, 0);
    ticks(1);
    check("R4", "irq at first expiry", irq_o, 1);
    check("R4", "stage at first expiry", stage_o, 2);
    ticks(2);
    check("R5", "stage after 2 of 3 ticks", stage_o, 2);
    check("R5", "tout_n before second expiry", tout_n_o, 1);
    ticks(1);
    check("R5", "tout_n at second expiry", tout_n_o, 0);
    check("R5", "stage expired", stage_o, 3);
    ticks(3);
    check("R5", "expired holds under ticks", stage_o, 3);
    wr(2'd3, 1);
    check("R6", "tout_n after reload", tout_n_o, 0);
    check("R7", "reload from expired", stage_o, 1);
    wr(2'd0, 0);
    check("R6", "tout_n after disable", tout_n_o, 0);
    do_reset();
    check("R6", "tout_n released by reset", tout_n_o, 1);
  endtask

  task automatic t_kick();
    do_reset();
    wr(2'd1, 3); wr(2'd2, 2);
    wr(2'd3, 1);
    check("R7", "reload while idle ignored", stage_o, 0);
    wr(2'd0, 1);
    ticks(2);
    wr(2'd3, 1);
    ticks(2);
    check("R7", "reload restarted stage one", stage_o, 1);
    check("R7", "no irq after reload", irq_o, 0);
    ticks(1);
    check("R7", "stage two after full count", stage_o, 2);
    ticks(1);
    wr(2'd3, 1);
    check("R7", "reload from stage two", stage_o, 1);
    ticks(2);
    check("R7", "stage one reloaded with first preload", stage_o, 1);
    ticks(1);
    check("R7", "stage two again", stage_o, 2);
    check("R7", "tout_n not asserted", tout_n_o, 1);
  endtask

  task automatic t_irq();
    do_reset();
    wr(2'd1, 1); wr(2'd2, 50); wr(2'd0, 1);
    ticks(1);
    check("R8", "irq set", irq_o, 1);
    wr(2'd3, 0);
    check("R8", "irq sticky", irq_o, 1);
    wr(2'd3, 2);
    check("R8", "irq cleared by W1C", irq_o, 0);
    wr(2'd3, 1);
    // expiry and clear on the same edge: expiry wins
    addr_i = 2'd3; wdata_i = 2; wr_i = 1'b1; tick_i = 1'b1;
    @(negedge clk);
    wr_i = 1'b0; tick_i = 1'b0;
    check("R8", "set wins over clear", irq_o, 1);
  endtask

  task automatic t_lock();
    do_reset();
    wr(2'd1, 2); wr(2'd2, 4);
    wr(2'd0, 3);
    check("R9", "running after enable with lock", running_o, 1);
    wr(2'd1, 10); wr(2'd2, 20);
    wr(2'd0, 0);
    check("R9", "disable ignored while locked", running_o, 1);
    ticks(2);
    check("R9", "first preload kept", stage_o, 2);
    wr(2'd3, 1);
    check("R9", "reload accepted while locked", stage_o, 1);
    ticks(2);
    ticks(3);
    check("R9", "second preload kept (3 of 4)", stage_o, 2);
    ticks(1);
    check("R9", "second stage expiry at 4", tout_n_o, 0);
    wr(2'd3, 2);
    check("R9", "irq clear accepted while locked", irq_o, 0);
  endtask

  task automatic t_zero();
    do_reset();
    wr(2'd1, 0); wr(2'd2, 0); wr(2'd0, 1);
    check("R10", "stage one entered", stage_o, 1);
    ticks(1);
    check("R10", "zero first preload ends in one tick", stage_o, 2);
    ticks(1);
    check("R10", "zero second preload ends in one tick", tout_n_o, 0);
  endtask

  task automatic t_disable();
    do_reset();
    wr(2'd1, 2); wr(2'd2, 9); wr(2'd0, 1);
    ticks(2);
    wr(2'd0, 0);
    check("R11", "stage idle after disable", stage_o, 0);
    check("R11", "running low after disable", running_o, 0);
    check("R11", "irq kept after disable", irq_o, 1);
    ticks(20);
    check("R11", "ticks ignored while idle", stage_o, 0);
    check("R11", "no timeout while idle", tout_n_o, 1);
    wr(2'd0, 1);
    ticks(1);
    check("R2", "re-enable loads first preload", stage_o, 1);
    ticks(1);
    check("R2", "re-enabled stage ends at 2", stage_o, 2);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_kick();
    t_irq();
    t_lock();
    t_zero();
    t_disable();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule